// File: doc/BRIEF.md
# STOP-Mode Wake Stabilization Timer

This block decides when the system clock can be used again after the chip leaves its low-power STOP state. A one-byte select register, written over a simple register bus, chooses how long to wait. The wait is a power of two of oscillator cycles. The block runs on the oscillator clock. It sees a STOP-entry request, a wake-up interrupt, an oscillator-running indication and one active-low reset. That reset stands for every reset source: the pin, power-on clear and low-voltage detection.

A wake by interrupt starts the programmed wait. Only cycles in which the oscillator is reported running are counted, so the time before oscillation starts is not part of the wait. The first half of the count is set aside for the PLL to lock, and the block raises a flag for that half. The second half lets the resonator settle. When the count completes, the clock-ready output rises and stays high, and a one-cycle pulse marks the moment. A wake by reset applies no wait, because the oscillator stabilizes while reset is held. The clock is reported ready as soon as reset is released.

Top module: `stw_wake_timer`

## Requirements
- R1: After reset the select register reads 0x04, clock-ready is high, and the PLL-phase flag and ready pulse are low.
- R2: Only bits 3:0 of the select register can be written; bits 7:4 ignore written data and always read as zero.
- R3: A select code of 0 to 4 in bits 3:0 sets a wait of 2^(MIN_EXP+code) oscillator-running cycles. MIN_EXP is 14 by default, which gives 2^14 to 2^18.
- R4: Any other code (5 to 15, including any code with bit 3 set) gives the longest wait, 2^(MIN_EXP+4) cycles.
- R5: A STOP request while the clock is ready drops clock-ready on the next cycle. Clock-ready then stays low until the wait after a wake interrupt has finished.
- R6: Cycles in which osc_run is low are not counted toward the wait.
- R7: The PLL-phase flag is high exactly while fewer than half of the wait's cycles have been counted. It is never high while clock-ready is high.
- R8: When the wait completes, clock-ready rises and ready_pulse is high for exactly that first cycle. Clock-ready then stays high until the next STOP request.
- R9: A register write during a wait does not change that wait's length. The wait length is captured from the register in the cycle the wake interrupt is taken.
- R10: A reset while in STOP or during a wait ends it. Clock-ready is high in the first cycle after reset release, with no count.
- R11: A wake interrupt while not stopped has no effect, and a STOP request while waiting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Combined active-low system reset, asynchronous assert |
| bus_wr | input | 1 | Write strobe for the select register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Select register read value |
| stop_req | input | 1 | Request to enter STOP |
| wake_irq | input | 1 | Wake-up interrupt |
| osc_run | input | 1 | Oscillator running indication |
| clk_ready | output | 1 | System clock usable |
| ready_pulse | output | 1 | One-cycle pulse when a wait completes |
| pll_phase | output | 1 | High during the PLL-lock half of the wait |

## Verification
The wait is run with the oscillator running every cycle, with one cycle in three missing, and with a ten-cycle delay before it starts. Counting only running cycles separates these cases, because the wall-clock time differs while the counted total must not. Every valid code and several prohibited codes, including codes with bit 3 set, are tried, so a decode error shows up as a wrong total. Further runs cover a rewrite of the register in the middle of a wait, a STOP request held during a wait, and a reset while stopped. These separate a wait length captured at wake from one read live, and a reset wake from an interrupt wake.

// File: rtl/stw_pkg.sv
package stw_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_STOP  = 2'd1,
      ST_COUNT = 2'd2
   } stw_state_e;

   localparam int unsigned SEL_FIELD_W = 4;
   localparam int unsigned SEL_CODES   = 1 << SEL_FIELD_W;
endpackage

// File: rtl/stw_sel_reg.sv
module stw_sel_reg #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned FIELD_W   = 4,
   parameter int unsigned RESET_VAL = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [FIELD_W-1:0] field_o,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned PAD_W = DATA_W - FIELD_W;

   generate
      if (FIELD_W >= DATA_W) begin : g_bad_width
         $error("stw_sel_reg: FIELD_W must be narrower than DATA_W");
      end
      if (RESET_VAL >= (1 << FIELD_W)) begin : g_bad_reset
         $error("stw_sel_reg: RESET_VAL does not fit the field");
      end
   endgenerate

   logic [FIELD_W-1:0] field_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) field_q <= FIELD_W'(RESET_VAL);
      else if (wr_en) field_q <= wdata[FIELD_W-1:0];
   end

   assign field_o = field_q;
   assign rdata   = {{PAD_W{1'b0}}, field_q};

   assert_upper_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:FIELD_W] == '0);

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rdata[FIELD_W-1:0] == $past(wdata[FIELD_W-1:0]));
endmodule

// File: rtl/stw_len_decode.sv
module stw_len_decode #(
   parameter int unsigned FIELD_W   = 4,
   parameter int unsigned MIN_EXP   = 14,
   parameter int unsigned NUM_CODES = 5,
   parameter int unsigned EXP_W     = 5
) (
   input  logic [FIELD_W-1:0] code_i,
   output logic [EXP_W-1:0]   exp_o
);
   localparam int unsigned N_ENTRIES = 1 << FIELD_W;
   localparam int unsigned MAX_EXP   = MIN_EXP + NUM_CODES - 1;

   generate
      if (NUM_CODES == 0 || NUM_CODES > N_ENTRIES) begin : g_bad_codes
         $error("stw_len_decode: NUM_CODES out of range");
      end
      if (MAX_EXP >= (1 << EXP_W)) begin : g_bad_exp
         $error("stw_len_decode: EXP_W too narrow");
      end
   endgenerate

   logic [EXP_W-1:0] table_w [N_ENTRIES];

   for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_entry
      if (gi < NUM_CODES) begin : g_legal
         assign table_w[gi] = EXP_W'(MIN_EXP + gi);
      end else begin : g_clamp
         assign table_w[gi] = EXP_W'(MAX_EXP);
      end
   end

   assign exp_o = table_w[code_i];
endmodule

// File: rtl/stw_count.sv
module stw_count #(
   parameter int unsigned MIN_EXP = 14,
   parameter int unsigned MAX_EXP = 18,
   parameter int unsigned EXP_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [EXP_W-1:0] exp_i,
   input  logic             active_i,
   input  logic             osc_run,
   output logic             done_o,
   output logic             pll_phase_o
);
   localparam int unsigned CNT_W = MAX_EXP + 1;

   generate
      if (MIN_EXP < 1) begin : g_bad_min
         $error("stw_count: MIN_EXP must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [EXP_W-1:0] exp_q;
   logic [CNT_W-1:0] last_w;
   logic [CNT_W-1:0] half_w;

   assign last_w = (CNT_W'(1) << exp_q) - CNT_W'(1);
   assign half_w = CNT_W'(1) << (exp_q - EXP_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= EXP_W'(MAX_EXP);
      end else if (start_i) begin
         cnt_q <= '0;
         exp_q <= exp_i;
      end else if (active_i && osc_run) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign done_o      = active_i && osc_run && (cnt_q == last_w);
   assign pll_phase_o = active_i && (cnt_q < half_w);

   assert_hold_without_osc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && !osc_run && !start_i) |=> $stable(cnt_q));

   assert_exp_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (exp_i >= EXP_W'(MIN_EXP) && exp_i <= EXP_W'(MAX_EXP)));

   assert_len_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && !start_i) |=> $stable(exp_q));
endmodule

// File: rtl/stw_wake_timer.sv
module stw_wake_timer #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned MIN_EXP    = 14,
   parameter int unsigned NUM_CODES  = 5,
   parameter int unsigned RESET_CODE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              stop_req,
   input  logic              wake_irq,
   input  logic              osc_run,
   output logic              clk_ready,
   output logic              ready_pulse,
   output logic              pll_phase
);
   import stw_pkg::*;

   localparam int unsigned MAX_EXP = MIN_EXP + NUM_CODES - 1;
   localparam int unsigned EXP_W   = $clog2(MAX_EXP + 1);

   stw_state_e           state_q, state_d;
   logic [SEL_FIELD_W-1:0] code_w;
   logic [EXP_W-1:0]     exp_w;
   logic                 start_w, active_w, done_w, pulse_q;

   stw_sel_reg #(
      .DATA_W   (DATA_W),
      .FIELD_W  (SEL_FIELD_W),
      .RESET_VAL(RESET_CODE)
   ) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr),
      .wdata  (bus_wdata),
      .field_o(code_w),
      .rdata  (bus_rdata)
   );

   stw_len_decode #(
      .FIELD_W  (SEL_FIELD_W),
      .MIN_EXP  (MIN_EXP),
      .NUM_CODES(NUM_CODES),
      .EXP_W    (EXP_W)
   ) u_dec (
      .code_i(code_w),
      .exp_o (exp_w)
   );

   stw_count #(
      .MIN_EXP(MIN_EXP),
      .MAX_EXP(MAX_EXP),
      .EXP_W  (EXP_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_w),
      .exp_i      (exp_w),
      .active_i   (active_w),
      .osc_run    (osc_run),
      .done_o     (done_w),
      .pll_phase_o(pll_phase)
   );

   assign active_w = (state_q == ST_COUNT);
   assign start_w  = (state_q == ST_STOP) && wake_irq;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:   if (stop_req) state_d = ST_STOP;
         ST_STOP:  if (wake_irq) state_d = ST_COUNT;
         ST_COUNT: if (done_w)   state_d = ST_RUN;
         default:  state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         pulse_q <= 1'b0;
      end else begin
         state_q <= state_d;
         pulse_q <= done_w;
      end
   end

   assign clk_ready   = (state_q == ST_RUN);
   assign ready_pulse = pulse_q;

   assert_stop_drops_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_ready && stop_req) |=> !clk_ready);

   assert_ready_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_ready && !stop_req) |=> clk_ready);

   assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ready_pulse |=> !ready_pulse);

   assert_pulse_with_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ready_pulse |-> clk_ready);

   assert_pll_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pll_phase |-> !clk_ready);

   assert_wake_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_ready && wake_irq && !stop_req) |=> clk_ready);
endmodule

// File: tb/stw_wake_timer_bench.sv
module stw_wake_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MIN_EXP    = 3;
   localparam int NUM_CODES  = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       stop_req = 1'b0;
   logic       wake_irq = 1'b0;
   logic       osc_run = 1'b1;
   logic       clk_ready, ready_pulse, pll_phase;

   int n_checks = 0;
   int n_fail   = 0;
   bit started  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stw_wake_timer #(.MIN_EXP(MIN_EXP), .NUM_CODES(NUM_CODES)) u_stw_wake_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .stop_req(stop_req), .wake_irq(wake_irq),
      .osc_run(osc_run), .clk_ready(clk_ready), .ready_pulse(ready_pulse),
      .pll_phase(pll_phase)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int wait_len(input logic [3:0] code);
      if (code < NUM_CODES) return 1 << (MIN_EXP + code);
      return 1 << (MIN_EXP + NUM_CODES - 1);
   endfunction

   // Reference model: 0 = running, 1 = stopped, 2 = waiting
   int         m_state = 0;
   int         m_cnt   = 0;
   int         m_total = 0;
   logic [3:0] m_reg   = 4'h4;
   bit         m_pulse = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_reg = 4'h4; m_pulse = 1'b0;
      end else begin
         m_pulse = 1'b0;
         case (m_state)
            0: if (stop_req) m_state = 1;
            1: if (wake_irq) begin
                  m_total = wait_len(m_reg); m_cnt = 0; m_state = 2;
               end
            default: if (osc_run) begin
                  m_cnt++;
                  if (m_cnt == m_total) begin m_state = 0; m_pulse = 1'b1; end
               end
         endcase
         if (bus_wr) m_reg = bus_wdata[3:0];
      end
   end

   always @(negedge clk) begin
      if (started) begin
         chk(bus_rdata == {4'h0, m_reg}, "R2 model rdata", bus_rdata, {4'h0, m_reg});
         chk(clk_ready == (m_state == 0), "R5 model clk_ready", clk_ready, m_state == 0);
         chk(pll_phase == (m_state == 2 && m_cnt < m_total/2), "R7 model pll_phase",
             pll_phase, m_state == 2 && m_cnt < m_total/2);
         chk(ready_pulse == m_pulse, "R8 model ready_pulse", ready_pulse, m_pulse);
      end
   end

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   // mode 0: oscillator always on; 1: every third cycle off; 2: first ten cycles off
   task automatic run_wake(input logic [7:0] wcode, input int mode, input bit midwrite,
                           input bit hold_stop, input string req);
      int n = 0;
      int k = 0;
      bit prev;
      int expv = wait_len(wcode[3:0]);
      @(posedge clk); #1 bus_wr = 1'b1; bus_wdata = wcode;
      @(posedge clk); #1 bus_wr = 1'b0; stop_req = 1'b1;
      @(posedge clk); #1 stop_req = 1'b0;
      chk(!clk_ready, "R5 stopped", clk_ready, 0);
      wake_irq = 1'b1; osc_run = 1'b0;
      @(posedge clk); #1 wake_irq = 1'b0; stop_req = hold_stop;
      forever begin
         case (mode)
            1: osc_run = (k % 3) != 2;
            2: osc_run = (k >= 10);
            default: osc_run = 1'b1;
         endcase
         prev = osc_run;
         if (midwrite && k == 4) begin bus_wr = 1'b1; bus_wdata = 8'h00; end
         else bus_wr = 1'b0;
         k++;
         @(posedge clk);
         if (prev) n++;
         #1;
         if (clk_ready || k > 5000) break;
      end
      bus_wr = 1'b0;
      stop_req = 1'b0;
      osc_run = 1'b1;
      chk(n == expv, req, n, expv);
      chk(ready_pulse == 1'b1, "R8 pulse at completion", ready_pulse, 1);
      @(posedge clk); #1;
      chk(ready_pulse == 1'b0 && clk_ready, "R8 pulse one cycle, ready held",
          {ready_pulse, clk_ready}, 1);
   endtask

   initial begin
      #1 rst_n = 1'b0;
      started = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk(bus_rdata == 8'h04, "R1 reset rdata", bus_rdata, 4);
      chk(clk_ready && !pll_phase && !ready_pulse, "R1 reset outputs",
          {clk_ready, pll_phase, ready_pulse}, 3'b100);

      @(posedge clk); #1 bus_wr = 1'b1; bus_wdata = 8'hF2;
      @(posedge clk); #1 bus_wr = 1'b0;
      chk(bus_rdata == 8'h02, "R2 upper bits ignored", bus_rdata, 2);

      for (int c = 0; c < NUM_CODES; c++)
         run_wake(8'(c), 0, 1'b0, 1'b0, "R3 legal code length");
      run_wake(8'h02, 1, 1'b0, 1'b0, "R6 gapped oscillator");
      run_wake(8'h03, 2, 1'b0, 1'b0, "R6 late oscillator start");
      run_wake(8'h05, 0, 1'b0, 1'b0, "R4 code 5 clamps");
      run_wake(8'h07, 1, 1'b0, 1'b0, "R4 code 7 clamps");
      run_wake(8'h08, 0, 1'b0, 1'b0, "R4 code 8 clamps");
      run_wake(8'hFC, 0, 1'b0, 1'b0, "R4 code 12 clamps");
      run_wake(8'h02, 0, 1'b1, 1'b0, "R9 mid-wait write keeps length");
      run_wake(8'h01, 0, 1'b0, 1'b1, "R11 stop held during wait");

      @(posedge clk); #1 wake_irq = 1'b1;
      @(posedge clk); #1 wake_irq = 1'b0;
      chk(clk_ready, "R11 wake while running", clk_ready, 1);

      @(posedge clk); #1 bus_wr = 1'b1; bus_wdata = 8'h01;
      @(posedge clk); #1 bus_wr = 1'b0; stop_req = 1'b1;
      @(posedge clk); #1 stop_req = 1'b0; osc_run = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      chk(clk_ready && !pll_phase, "R10 ready right after reset", clk_ready, 1);
      chk(bus_rdata == 8'h04, "R10 register reset", bus_rdata, 4);
      repeat (4) @(posedge clk);
      #1 chk(clk_ready && !ready_pulse, "R10 no wait after reset", clk_ready, 1);
      osc_run = 1'b1;
      repeat (2) @(posedge clk);
      finish_up();
   end
endmodule